// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block keeps a live six-flag status word for an I2C slave port. It is fed by the already decoded events of the bus and of software access. Bus events are start and stop conditions, byte completion with an address-or-data tag, the captured direction bit, the address-match result and a not-acknowledge. Software events are a read of the receive buffer, a write of the transmit buffer, the end of shifting a transmit byte, and a write of the own-address register. Bit sampling, the shift register and the address comparator sit outside the block.

The flags cover five things:
- which bus condition was seen most recently (start or stop);
- whether the last byte moved was an address byte or a data byte;
- the direction of the current transfer;
- a request to reload the address register during 10-bit addressing;
- whether the byte buffer holds something that has not yet been consumed.

Each flag is a register. It changes on the clock edge that samples its event. A module enable clears the whole word and holds it cleared.

Top module: `i2c_slave_status`

## Requirements
- R1: While `rst_n` is low, and on the first edge with `en` low, `status` becomes 0. While `en` stays low, no event input changes `status`.
- R2: A start pulse sets the start flag (`status[4]`) and clears the stop flag (`status[5]`). A stop pulse does the opposite. When both arrive in the same cycle, the stop flag wins. The two flags are never 1 together.
- R3: On every `byte_done`, the data/address flag (`status[3]`) takes the value of `byte_is_data` (1 = data byte, 0 = address byte).
- R4: An address byte (`byte_done` with `byte_is_data`=0) that has `addr_match`=1 loads `byte_rw` into the read/write flag (`status[2]`; 1 = read, 0 = write). An address byte without a match leaves the flag unchanged.
- R5: A start, stop or `nack_det` pulse forces the read/write flag to 0. When a matched address byte arrives in the same cycle, the captured value wins.
- R6: On the receive path, the buffer-full flag (`status[0]`) is set by every address byte and by every data byte while the read/write flag is 0. It is cleared by `rx_buf_rd`.
- R7: On the transmit path, `tx_buf_wr` sets buffer-full and `tx_shift_done` clears it. A data byte completing while the read/write flag is 1 leaves buffer-full unchanged, and so do `nack_det` and stop pulses. When a set and a clear arrive in the same cycle, the set wins.
- R8: The update-address flag (`status[1]`) is set by a matched address byte while `ten_bit_mode`=1. It is cleared by `addr_reg_wr`, and a set in the same cycle wins. The flag reads 0 whenever `ten_bit_mode`=0. A matched address byte seen while `ten_bit_mode`=0 does not set it.
- R9: The status word is packed, from bit 5 down to bit 0, as stop, start, data/address, read/write, update-address, buffer-full.
- R10: An event changes `status` only after the rising clock edge that samples it. In the cycle the event is applied, `status` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable; low clears and holds all flags |
| start_det | input | 1 | Start-condition pulse |
| stop_det | input | 1 | Stop-condition pulse |
| byte_done | input | 1 | Byte-complete strobe |
| byte_is_data | input | 1 | Tag of the completed byte: 1 data, 0 address |
| byte_rw | input | 1 | Direction bit of the completed address byte |
| addr_match | input | 1 | Completed address byte matched the own address |
| nack_det | input | 1 | Not-acknowledge pulse |
| ten_bit_mode | input | 1 | 10-bit addressing mode selected |
| addr_reg_wr | input | 1 | Software wrote the own-address register |
| rx_buf_rd | input | 1 | Software read the receive buffer |
| tx_buf_wr | input | 1 | Software wrote the transmit buffer |
| tx_shift_done | input | 1 | Transmit byte fully shifted out |
| status | output | 6 | Status word: {stop, start, data/addr, rw, update-addr, buf-full} |

## Verification
The bench builds the block with its default parameter, which keeps the 10-bit update-address register present. That makes the reads-zero masking, the set-over-clear priority against an address-register write, and the case of a match that is not stored while the mode is off all reachable. Directed write and read transfers run in sequence, so the direction flag drives the choice between receive and transmit for buffer-full. Same-cycle collisions cover start against stop, capture against window closure, and transmit set against clear.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

  typedef struct packed {
    logic stop_last;
    logic start_last;
    logic data_byte;
    logic rd_dir;
    logic upd_addr;
    logic buf_full;
  } stat_t;

  localparam int STAT_W = $bits(stat_t);

  function automatic stat_t pack_stat(input logic p, input logic s, input logic d,
                                      input logic r, input logic u, input logic b);
    stat_t w;
    w.stop_last  = p;
    w.start_last = s;
    w.data_byte  = d;
    w.rd_dir     = r;
    w.upd_addr   = u;
    w.buf_full   = b;
    return w;
  endfunction

  // Buffer-full next value: a set outranks a clear.
  function automatic logic full_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/i2cst_cond.sv
module i2cst_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_ev,
  input  logic stop_ev,
  output logic start_q,
  output logic stop_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (!en) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (stop_ev) begin
      stop_q  <= 1'b1;
      start_q <= 1'b0;
    end else if (start_ev) begin
      start_q <= 1'b1;
      stop_q  <= 1'b0;
    end
  end

  // R2
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (stop_q && !start_q));

  // R2
  start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> (start_q && !stop_q));

  // R2
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && stop_q));

endmodule

// File: rtl/i2cst_addr.sv
module i2cst_addr #(
  parameter bit TEN_BIT_SUPPORT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic byte_ev,
  input  logic is_data,
  input  logic rw_bit,
  input  logic match,
  input  logic close_ev,
  input  logic ten_bit_mode,
  input  logic addr_wr_ev,
  output logic da_q,
  output logic rw_q,
  output logic ua_flag
);

  logic capture;
  assign capture = byte_ev & ~is_data & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       da_q <= 1'b0;
    else if (!en)     da_q <= 1'b0;
    else if (byte_ev) da_q <= is_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rw_q <= 1'b0;
    else if (!en)      rw_q <= 1'b0;
    else if (capture)  rw_q <= rw_bit;
    else if (close_ev) rw_q <= 1'b0;
  end

  // R3
  da_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ev |=> (da_q == $past(is_data)));

  // R4
  rw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (rw_q == $past(rw_bit)));

  // R5
  rw_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_ev && !capture) |=> !rw_q);

  generate
    if (TEN_BIT_SUPPORT) begin : g_ua
      logic ua_q;
      logic ua_set;
      assign ua_set = capture & ten_bit_mode;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ua_q <= 1'b0;
        else if (!en)        ua_q <= 1'b0;
        else if (ua_set)     ua_q <= 1'b1;
        else if (addr_wr_ev) ua_q <= 1'b0;
      end

      assign ua_flag = ua_q & ten_bit_mode;

      // R8
      ua_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ua_set |=> ua_q);

      // R8
      ua_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr_ev && !ua_set) |=> !ua_q);
    end else begin : g_no_ua
      assign ua_flag = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/i2cst_buf.sv
module i2cst_buf
  import i2cst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rx_land,
  input  logic rx_rd_ev,
  input  logic tx_wr_ev,
  input  logic tx_out_ev,
  output logic bf_q
);

  logic set_ev, clr_ev;
  assign set_ev = rx_land | tx_wr_ev;
  assign clr_ev = rx_rd_ev | tx_out_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bf_q <= 1'b0;
    else if (!en) bf_q <= 1'b0;
    else          bf_q <= full_next(bf_q, set_ev, clr_ev);
  end

  // R6
  bf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> bf_q);

  // R7
  bf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !bf_q);

  // R7
  bf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set_ev && !clr_ev) |=> $stable(bf_q));

endmodule

// File: rtl/i2c_slave_status.sv
module i2c_slave_status
  import i2cst_pkg::*;
#(
  parameter bit TEN_BIT_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic              byte_is_data,
  input  logic              byte_rw,
  input  logic              addr_match,
  input  logic              nack_det,
  input  logic              ten_bit_mode,
  input  logic              addr_reg_wr,
  input  logic              rx_buf_rd,
  input  logic              tx_buf_wr,
  input  logic              tx_shift_done,
  output logic [STAT_W-1:0] status
);

  // Named internal events, gated by the enable.
  logic start_ev, stop_ev, byte_ev, nack_ev, close_ev;
  logic addr_wr_ev, rx_rd_ev, tx_wr_ev, tx_out_ev, rx_land;
  logic start_q, stop_q, da_q, rw_q, ua_flag, bf_q;
  stat_t stat;

  assign start_ev   = en & start_det;
  assign stop_ev    = en & stop_det;
  assign byte_ev    = en & byte_done;
  assign nack_ev    = en & nack_det;
  assign close_ev   = start_ev | stop_ev | nack_ev;
  assign addr_wr_ev = en & addr_reg_wr;
  assign rx_rd_ev   = en & rx_buf_rd;
  assign tx_wr_ev   = en & tx_buf_wr;
  assign tx_out_ev  = en & tx_shift_done;
  // Address bytes always land; data bytes land only while writing to the slave.
  assign rx_land    = byte_ev & (~byte_is_data | ~rw_q);

  i2cst_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .start_q  (start_q),
    .stop_q   (stop_q)
  );

  i2cst_addr #(.TEN_BIT_SUPPORT(TEN_BIT_SUPPORT)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .byte_ev      (byte_ev),
    .is_data      (byte_is_data),
    .rw_bit       (byte_rw),
    .match        (addr_match),
    .close_ev     (close_ev),
    .ten_bit_mode (ten_bit_mode),
    .addr_wr_ev   (addr_wr_ev),
    .da_q         (da_q),
    .rw_q         (rw_q),
    .ua_flag      (ua_flag)
  );

  i2cst_buf u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .rx_land   (rx_land),
    .rx_rd_ev  (rx_rd_ev),
    .tx_wr_ev  (tx_wr_ev),
    .tx_out_ev (tx_out_ev),
    .bf_q      (bf_q)
  );

  assign stat   = pack_stat(stop_q, start_q, da_q, rw_q, ua_flag, bf_q);
  assign status = stat;

  // R1
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (status == '0));

  // R8
  ua_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ten_bit_mode |-> !status[1]);

  // R7
  tx_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && byte_is_data && rw_q && !tx_wr_ev && !tx_out_ev && !rx_rd_ev)
      |=> $stable(bf_q));

endmodule

// File: tb/sim_i2c_slave_status.sv
module sim_i2c_slave_status;

  logic clk = 1'b0;
  logic rst_n, en, start_det, stop_det, byte_done, byte_is_data, byte_rw;
  logic addr_match, nack_det, ten_bit_mode, addr_reg_wr, rx_buf_rd, tx_buf_wr, tx_shift_done;
  logic [5:0] status;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  i2c_slave_status u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .byte_is_data(byte_is_data), .byte_rw(byte_rw),
    .addr_match(addr_match), .nack_det(nack_det), .ten_bit_mode(ten_bit_mode),
    .addr_reg_wr(addr_reg_wr), .rx_buf_rd(rx_buf_rd), .tx_buf_wr(tx_buf_wr),
    .tx_shift_done(tx_shift_done), .status(status)
  );

  // Expected word: {stop, start, data/addr, rw, update-addr, buf-full}
  function automatic logic [5:0] ex(input bit p, input bit s, input bit d,
                                    input bit r, input bit u, input bit b);
    return {p, s, d, r, u, b};
  endfunction

  task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: status=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic clear_pulses();
    start_det = 0; stop_det = 0; byte_done = 0; byte_is_data = 0; byte_rw = 0;
    addr_match = 0; nack_det = 0; addr_reg_wr = 0; rx_buf_rd = 0; tx_buf_wr = 0;
    tx_shift_done = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    clear_pulses();
  endtask

  task automatic addr_byte(input bit rw, input bit m);
    byte_done = 1; byte_is_data = 0; byte_rw = rw; addr_match = m;
  endtask

  task automatic data_byte();
    byte_done = 1; byte_is_data = 1;
  endtask

  task automatic t_reset();
    rst_n = 0; en = 0; ten_bit_mode = 0; clear_pulses();
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", status, 6'b0);
    rst_n = 1; en = 1;
    tick();
    chk("R1 enabled idle", status, 6'b0);
  endtask

  task automatic t_start();
    start_det = 1;
    #1 chk("R10 before edge", status, 6'b0);
    tick();
    chk("R2 start", status, ex(0,1,0,0,0,0));
    chk("R9 start bit4", {5'b0, status[4]}, 6'd1);
  endtask

  task automatic t_write_xfer();
    addr_byte(0, 1); tick();
    chk("R6 R4 write address", status, ex(0,1,0,0,0,1));
    chk("R9 full bit0", {5'b0, status[0]}, 6'd1);
    rx_buf_rd = 1; tick();
    chk("R6 read clears", status, ex(0,1,0,0,0,0));
    data_byte(); tick();
    chk("R3 R6 data byte", status, ex(0,1,1,0,0,1));
    nack_det = 1; tick();
    chk("R7 nack keeps full", status, ex(0,1,1,0,0,1));
    rx_buf_rd = 1; tick();
    chk("R6 read clears data", status, ex(0,1,1,0,0,0));
    stop_det = 1; tick();
    chk("R2 stop", status, ex(1,0,1,0,0,0));
  endtask

  task automatic t_read_xfer();
    start_det = 1; tick();
    chk("R2 restart", status, ex(0,1,1,0,0,0));
    addr_byte(1, 1); tick();
    chk("R4 read address", status, ex(0,1,0,1,0,1));
    rx_buf_rd = 1; tick();
    chk("R6 read address consumed", status, ex(0,1,0,1,0,0));
    tx_buf_wr = 1; tick();
    chk("R7 tx write sets", status, ex(0,1,0,1,0,1));
    data_byte(); tick();
    chk("R7 R3 tx byte keeps full", status, ex(0,1,1,1,0,1));
    tx_shift_done = 1; tick();
    chk("R7 shift clears", status, ex(0,1,1,1,0,0));
    tx_buf_wr = 1; tx_shift_done = 1; tick();
    chk("R7 set beats clear", status, ex(0,1,1,1,0,1));
    tx_shift_done = 1; tick();
    chk("R7 shift clears again", status, ex(0,1,1,1,0,0));
    nack_det = 1; tick();
    chk("R5 nack closes rw", status, ex(0,1,1,0,0,0));
  endtask

  task automatic t_rw_edges();
    addr_byte(1, 0); tick();
    chk("R4 no match keeps rw", status, ex(0,1,0,0,0,1));
    rx_buf_rd = 1; tick();
    chk("R6 clear", status, ex(0,1,0,0,0,0));
    addr_byte(1, 1); stop_det = 1; tick();
    chk("R5 capture beats stop", status, ex(1,0,0,1,0,1));
    rx_buf_rd = 1; tick();
    chk("R6 clear2", status, ex(1,0,0,1,0,0));
    start_det = 1; tick();
    chk("R5 start closes rw", status, ex(0,1,0,0,0,0));
    start_det = 1; stop_det = 1; tick();
    chk("R2 stop wins tie", status, ex(1,0,0,0,0,0));
    stop_det = 1; tick();
    chk("R7 stop keeps full", status, ex(1,0,0,0,0,0));
  endtask

  task automatic t_ten_bit();
    ten_bit_mode = 1;
    addr_byte(0, 1); tick();
    chk("R8 ua set", status, ex(1,0,0,0,1,1));
    addr_reg_wr = 1; tick();
    chk("R8 ua cleared", status, ex(1,0,0,0,0,1));
    addr_byte(0, 1); addr_reg_wr = 1; tick();
    chk("R8 set beats clear", status, ex(1,0,0,0,1,1));
    ten_bit_mode = 0; tick();
    chk("R8 reads zero off mode", status, ex(1,0,0,0,0,1));
    ten_bit_mode = 1; tick();
    chk("R8 stored flag back", status, ex(1,0,0,0,1,1));
    addr_reg_wr = 1; rx_buf_rd = 1; tick();
    chk("R8 R6 both cleared", status, ex(1,0,0,0,0,0));
    ten_bit_mode = 0;
    addr_byte(0, 1); tick();
    ten_bit_mode = 1; tick();
    chk("R8 no set off mode", status, ex(1,0,0,0,0,1));
    ten_bit_mode = 0;
  endtask

  task automatic t_disable();
    en = 0; tick();
    chk("R1 disable clears", status, 6'b0);
    start_det = 1; tx_buf_wr = 1; addr_byte(1, 1); tick();
    chk("R1 events ignored", status, 6'b0);
    en = 1; tick();
    chk("R1 re-enable idle", status, 6'b0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: status=%b expected=done", status);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_start();
    t_write_xfer();
    t_read_xfer();
    t_rw_edges();
    t_ten_bit();
    t_disable();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule